// File: doc/BRIEF.md
# Blinded-Subcarrier Common Phase Corrector

This block removes the common phase error left on equalized OFDM symbols. Its input is a stream of complex frequency-domain samples, one per used subcarrier. Each sample carries its subcarrier index and a flag that marks the first sample of a symbol. At the transmitter, one data subcarrier in every symbol is overwritten with a QPSK point whose phase is known in advance. That subcarrier is the phase reference.

The block collects a whole symbol in a local buffer, because the reference may sit anywhere in it. An iterative CORDIC in vectoring mode measures the angle of the reference sample. The expected QPSK angle is subtracted, and the difference modulo one full turn is the symbol's phase error. The same CORDIC, in rotation mode, then turns every other sample of that symbol back by this angle. A fixed multiply cancels the CORDIC gain.

The corrected samples leave in input order with the reference removed. The first one is flagged as the start of the symbol. A new estimate is taken for every symbol, with no averaging across symbols. A symbol that is cut short by a new start flag is thrown away and reported with an error pulse.

Top module: `cpe_corrector`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `sym_err` is 0.
- R2: No output appears until all NSC (50) samples of a symbol have been accepted. `in_ready` stays 0 from that acceptance until the symbol's last corrected sample has been taken.
- R3: Each complete symbol yields exactly NSC-1 (49) outputs, in input order. The sample whose `in_idx` equals `cfg_ref_idx` is left out. After the last output, `in_ready` returns to 1.
- R4: `out_sos` is 1 on the first output of a symbol and 0 on the other 48.
- R5: The phase error is the angle of the reference sample minus the expected QPSK angle, taken modulo a full turn. Every output equals its input sample rotated by minus that error, within 3 LSB on each of I and Q, for any error angle including ones near ±180°.
- R6: When the reference lies exactly on its expected point, each output equals its input within 3 LSB, so the CORDIC gain is fully removed.
- R7: Each symbol uses only its own reference. Two consecutive symbols with different phase errors are each corrected by their own angle.
- R8: A start flag accepted while 1 to NSC-1 samples of a symbol are held drops the partial symbol and raises `sym_err` for exactly one cycle, in the cycle after that acceptance. The flagged sample then opens a new symbol.
- R9: A sample without a start flag that is accepted while no symbol is open is discarded. It has no effect on the outputs and raises no error.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_re`, `out_im` and `out_sos` hold steady.
- R11: `cfg_ref_code` selects the expected reference angle: 00 is 45°, 01 is 135°, 10 is 225°, 11 is 315°.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_ref_idx | input | 6 | Subcarrier index of the reference (static) |
| cfg_ref_code | input | 2 | Expected QPSK point of the reference (static) |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can take an input sample |
| in_sos | input | 1 | Input sample is the first of a symbol |
| in_idx | input | 6 | Subcarrier index of the input sample |
| in_re | input | 16 | Input in-phase component, signed |
| in_im | input | 16 | Input quadrature component, signed |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream takes the output sample |
| out_sos | output | 1 | Output is the first corrected sample of a symbol |
| out_re | output | 16 | Corrected in-phase component, signed |
| out_im | output | 16 | Corrected quadrature component, signed |
| sym_err | output | 1 | One-cycle pulse when a partial symbol is dropped |

## Verification
Two functions can fall in the same cycle, and both are provoked on purpose.

The first case is a start flag that arrives while a symbol is only partly collected. In that one acceptance the block must drop the held samples and also open a new symbol with the flagged sample. The bench sends 20 samples and then a full symbol. It counts the error pulses and checks that all 49 outputs match the new symbol only.

The second case is a held output, when downstream stalls while the shared CORDIC has already finished its result. The bench holds `out_ready` low for several cycles at a time and checks that the presented sample neither changes nor is lost.

// File: rtl/cpe_pkg.sv
package cpe_pkg;
    localparam int SW = 16;

    typedef struct packed {
        logic signed [SW-1:0] re;
        logic signed [SW-1:0] im;
    } cplx_t;

    typedef enum logic [2:0] {
        S_FILL, S_VSTART, S_VWAIT, S_RSEL, S_RWAIT, S_SEND
    } st_e;
endpackage

// File: rtl/cpe_symbuf.sv
module cpe_symbuf
    import cpe_pkg::*;
#(
    parameter int DEPTH = 50,
    parameter int AB    = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AB-1:0] wr_addr,
    input  logic          wr_ref,
    input  cplx_t         wr_data,
    input  logic [AB-1:0] rd_addr,
    output logic          rd_ref,
    output cplx_t         rd_data
);
    logic [2*SW:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_addr] <= {wr_ref, wr_data};
    end

    assign {rd_ref, rd_data} = mem_q[rd_addr];

    // writes only land inside the symbol buffer (R3)
    assert_wr_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_addr) < DEPTH));
endmodule

// File: rtl/cpe_cordic.sv
module cpe_cordic
    import cpe_pkg::*;
#(
    parameter int ITER = 16,
    parameter int AW   = 20,
    parameter int GB   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          rot_mode,
    input  cplx_t         din,
    input  logic [AW-1:0] zin,
    output logic          done,
    output cplx_t         dout,
    output logic [AW-1:0] zout
);
    localparam int  IW  = SW + GB + 2;
    localparam int  ITW = $clog2(ITER + 1);
    localparam int  FB  = 16;
    localparam int  SH  = FB + GB;
    localparam int  PW  = IW + FB + 2;
    localparam real PI  = 3.14159265358979323846;

    function automatic logic [ITER*AW-1:0] mk_atan();
        logic [ITER*AW-1:0] t;
        real p;
        t = '0;
        p = 1.0;
        for (int i = 0; i < ITER; i++) begin
            t[i*AW +: AW] = AW'($rtoi($atan(p) / (2.0 * PI) * (2.0 ** AW) + 0.5));
            p = p / 2.0;
        end
        return t;
    endfunction

    function automatic int inv_gain();
        real g;
        real p;
        g = 1.0;
        p = 1.0;
        for (int i = 0; i < ITER; i++) begin
            g = g * $sqrt(1.0 + p * p);
            p = p / 2.0;
        end
        return $rtoi((2.0 ** FB) / g + 0.5);
    endfunction

    localparam logic [ITER*AW-1:0]  ATAN = mk_atan();
    localparam int                  INVK = inv_gain();
    localparam logic [AW-1:0]       HALF = AW'(1) << (AW - 1);
    localparam logic signed [PW-1:0] RND = PW'(2 ** (SH - 1));
    localparam logic signed [PW-1:0] HI  = PW'(2 ** (SW - 1) - 1);
    localparam logic signed [PW-1:0] LO  = -HI - PW'(1);

    typedef struct packed {
        logic                 busy;
        logic                 mode;
        logic [ITW-1:0]       it;
        logic signed [IW-1:0] x;
        logic signed [IW-1:0] y;
        logic [AW-1:0]        z;
        logic                 done;
        cplx_t                res;
    } cst_t;

    cst_t q, d;
    logic signed [IW-1:0] sx, sy, lx, ly;
    logic [AW-1:0]        at;
    logic signed [PW-1:0] px, py, rx, ry;

    function automatic logic signed [SW-1:0] sat(input logic signed [PW-1:0] v);
        if (v > HI) return HI[SW-1:0];
        if (v < LO) return LO[SW-1:0];
        return v[SW-1:0];
    endfunction

    always_comb begin
        d      = q;
        d.done = 1'b0;
        sx     = q.x >>> q.it;
        sy     = q.y >>> q.it;
        at     = (int'(q.it) < ITER) ? ATAN[int'(q.it)*AW +: AW] : '0;
        lx     = {{(IW-SW-GB){din.re[SW-1]}}, din.re, {GB{1'b0}}};
        ly     = {{(IW-SW-GB){din.im[SW-1]}}, din.im, {GB{1'b0}}};
        px     = PW'(q.x) * PW'(INVK);
        py     = PW'(q.y) * PW'(INVK);
        rx     = (px + RND) >>> SH;
        ry     = (py + RND) >>> SH;
        if (!q.busy) begin
            if (start) begin
                d.busy = 1'b1;
                d.mode = rot_mode;
                d.it   = '0;
                d.x    = lx;
                d.y    = ly;
                if (rot_mode) begin
                    d.z = zin;
                    if (zin[AW-1] ^ zin[AW-2]) begin
                        d.x = -lx;
                        d.y = -ly;
                        d.z = zin + HALF;
                    end
                end else begin
                    d.z = '0;
                    if (lx[IW-1]) begin
                        d.x = -lx;
                        d.y = -ly;
                        d.z = HALF;
                    end
                end
            end
        end else if (int'(q.it) == ITER) begin
            d.busy   = 1'b0;
            d.done   = 1'b1;
            d.res.re = sat(rx);
            d.res.im = sat(ry);
        end else begin
            d.it = q.it + 1'b1;
            if (q.mode ? !q.z[AW-1] : q.y[IW-1]) begin
                d.x = q.x - sy;
                d.y = q.y + sx;
                d.z = q.mode ? q.z - at : q.z - at;
            end else begin
                d.x = q.x + sy;
                d.y = q.y - sx;
                d.z = q.z + at;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done = q.done;
    assign dout = q.res;
    assign zout = q.z;

    // a result is announced once, then the engine idles (R5)
    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);
    // the controller never restarts a busy engine (R5)
    assert_start_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !q.busy);
endmodule

// File: rtl/cpe_corrector.sv
module cpe_corrector
    import cpe_pkg::*;
#(
    parameter int NSC  = 50,
    parameter int ITER = 16,
    parameter int AW   = 20,
    parameter int IXW  = $clog2(NSC)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IXW-1:0]       cfg_ref_idx,
    input  logic [1:0]           cfg_ref_code,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic                 in_sos,
    input  logic [IXW-1:0]       in_idx,
    input  logic signed [SW-1:0] in_re,
    input  logic signed [SW-1:0] in_im,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic                 out_sos,
    output logic signed [SW-1:0] out_re,
    output logic signed [SW-1:0] out_im,
    output logic                 sym_err
);
    localparam int CW = $clog2(NSC + 1);

    typedef struct packed {
        st_e           st;
        logic [CW-1:0] cnt;
        logic [CW-1:0] rd;
        cplx_t         refs;
        logic [AW-1:0] corr;
        logic          first;
        logic          err;
        cplx_t         obuf;
    } top_t;

    top_t q, d;

    logic          wr_en, rd_ref, is_ref, cs, cmode, cdone, open;
    logic [CW-1:0] wr_addr;
    cplx_t         rd_data, cin, cout;
    logic [AW-1:0] czin, cz, expang;

    assign expang = {cfg_ref_code, 1'b1, {(AW-3){1'b0}}};
    assign is_ref = (in_idx == cfg_ref_idx);
    assign open   = in_sos || (q.cnt != '0);

    always_comb begin
        d       = q;
        d.err   = 1'b0;
        wr_en   = 1'b0;
        wr_addr = q.cnt;
        cs      = 1'b0;
        cmode   = 1'b0;
        cin     = q.refs;
        czin    = q.corr;
        unique case (q.st)
            S_FILL: if (in_valid) begin
                if (in_sos) begin
                    d.err   = (q.cnt != '0);
                    wr_addr = '0;
                    d.cnt   = CW'(1);
                end else if (q.cnt != '0) begin
                    d.cnt = q.cnt + 1'b1;
                end
                wr_en = open;
                if (open && is_ref) d.refs = '{re: in_re, im: in_im};
                if (d.cnt == CW'(NSC)) d.st = S_VSTART;
            end
            S_VSTART: begin
                cs   = 1'b1;
                d.st = S_VWAIT;
            end
            S_VWAIT: if (cdone) begin
                d.corr  = expang - cz;
                d.rd    = '0;
                d.first = 1'b1;
                d.st    = S_RSEL;
            end
            S_RSEL: begin
                cin   = rd_data;
                cmode = 1'b1;
                if (q.rd == CW'(NSC)) begin
                    d.cnt = '0;
                    d.st  = S_FILL;
                end else if (rd_ref) begin
                    d.rd = q.rd + 1'b1;
                end else begin
                    cs   = 1'b1;
                    d.st = S_RWAIT;
                end
            end
            S_RWAIT: if (cdone) begin
                d.obuf = cout;
                d.st   = S_SEND;
            end
            S_SEND: if (out_ready) begin
                d.first = 1'b0;
                d.rd    = q.rd + 1'b1;
                d.st    = S_RSEL;
            end
            default: d.st = S_FILL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    cpe_symbuf #(.DEPTH(NSC), .AB(CW)) u_buf (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_ref(is_ref),
        .wr_data('{re: in_re, im: in_im}), .rd_addr(q.rd), .rd_ref(rd_ref), .rd_data(rd_data)
    );

    cpe_cordic #(.ITER(ITER), .AW(AW)) u_cordic (
        .clk(clk), .rst_n(rst_n), .start(cs), .rot_mode(cmode), .din(cin), .zin(czin),
        .done(cdone), .dout(cout), .zout(cz)
    );

    assign in_ready  = (q.st == S_FILL);
    assign out_valid = (q.st == S_SEND);
    assign out_sos   = out_valid && q.first;
    assign out_re    = q.obuf.re;
    assign out_im    = q.obuf.im;
    assign sym_err   = q.err;

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_re) && $stable(out_im) && $stable(out_sos)));
    assert_full_before_out_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (q.cnt == CW'(NSC)));
    assert_stop_intake_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !in_sos && q.cnt == CW'(NSC-1)) |=> !in_ready);
    assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sym_err |-> $past(in_valid && in_ready && in_sos));
    assert_sos_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sos && out_ready) |=> !out_sos);
endmodule

// File: tb/tb_cpe_corrector.sv
module tb_cpe_corrector;
    localparam int  NSC = 50;
    localparam real PI  = 3.14159265358979323846;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [5:0] cfg_ref_idx = '0;
    logic [1:0] cfg_ref_code = '0;
    logic in_valid = 1'b0, in_sos = 1'b0, out_ready = 1'b1;
    logic [5:0] in_idx = '0;
    logic signed [15:0] in_re = '0, in_im = '0;
    logic in_ready, out_valid, out_sos, sym_err;
    logic signed [15:0] out_re, out_im;

    int total = 0, bad = 0, err_seen = 0;

    always #4 clk = ~clk;

    cpe_corrector dut (
        .clk(clk), .rst_n(rst_n), .cfg_ref_idx(cfg_ref_idx), .cfg_ref_code(cfg_ref_code),
        .in_valid(in_valid), .in_ready(in_ready), .in_sos(in_sos), .in_idx(in_idx),
        .in_re(in_re), .in_im(in_im), .out_valid(out_valid), .out_ready(out_ready),
        .out_sos(out_sos), .out_re(out_re), .out_im(out_im), .sym_err(sym_err)
    );

    always @(negedge clk) if (rst_n && sym_err) err_seen++;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int rnd(input real v);
        return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
    endfunction

    function automatic int dre(input int k, input int seed);
        return ((k * 1237 + seed * 311) % 28000) - 14000;
    endfunction

    function automatic int dim(input int k, input int seed);
        return ((k * 733 + seed * 977) % 24000) - 12000;
    endfunction

    task automatic feed(input bit sos, input int idx, input int re, input int im);
        @(negedge clk);
        in_valid = 1'b1;
        in_sos = sos;
        in_idx = 6'(idx);
        in_re = 16'(re);
        in_im = 16'(im);
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // full symbol: data at each index, reference at ref_idx rotated by th_deg off its expected point
    task automatic run_symbol(input int ref_idx, input int code, input real th_deg, input int seed,
                              input bit bp, input int err_exp, input string tag);
        real phi, thm, c, s;
        int  rr, ri, e0, er, ei, k;
        e0 = err_seen;
        cfg_ref_idx = 6'(ref_idx);
        cfg_ref_code = 2'(code);
        phi = (45.0 + 90.0 * code + th_deg) * PI / 180.0;
        rr = rnd(20000.0 * $cos(phi));
        ri = rnd(20000.0 * $sin(phi));
        for (int j = 0; j < NSC; j++) begin
            if (j == NSC - 1)
                chk(!out_valid, "R2", "output before symbol complete", int'(out_valid), 0);
            if (j == ref_idx) feed(j == 0, j, rr, ri);
            else              feed(j == 0, j, dre(j, seed), dim(j, seed));
        end
        chk(!in_ready, "R2", "intake after full symbol", int'(in_ready), 0);
        thm = $atan2(real'(ri), real'(rr)) - (45.0 + 90.0 * code) * PI / 180.0;
        c = $cos(thm);
        s = $sin(thm);
        k = 0;
        for (int n = 0; n < NSC - 1; n++) begin
            int wd = 0;
            if (k == ref_idx) k++;
            while (!out_valid && wd < 100) begin @(negedge clk); wd++; end
            if (bp && (n % 7 == 0)) begin
                logic signed [15:0] r0, i0;
                out_ready = 1'b0;
                r0 = out_re;
                i0 = out_im;
                repeat (3) @(negedge clk);
                chk(out_valid && out_re == r0 && out_im == i0, "R10", "held output re",
                    int'(out_re), int'(r0));
                out_ready = 1'b1;
            end
            er = rnd(dre(k, seed) * c + dim(k, seed) * s);
            ei = rnd(dim(k, seed) * c - dre(k, seed) * s);
            chk(out_valid, "R3", "output missing", int'(out_valid), 1);
            chk(out_sos == (n == 0), "R4", "start flag", int'(out_sos), int'(n == 0));
            chk(int'(out_re) - er <= 3 && er - int'(out_re) <= 3, tag, "corrected re", int'(out_re), er);
            chk(int'(out_im) - ei <= 3 && ei - int'(out_im) <= 3, tag, "corrected im", int'(out_im), ei);
            @(negedge clk);
            k++;
        end
        repeat (30) @(negedge clk);
        chk(!out_valid, "R3", "extra output after 49", int'(out_valid), 0);
        chk(in_ready, "R3", "intake reopened", int'(in_ready), 1);
        chk(err_seen - e0 == err_exp, "R8", "error pulses", err_seen - e0, err_exp);
    endtask

    task automatic t_reset();
        chk(in_ready, "R1", "in_ready after reset", int'(in_ready), 1);
        chk(!out_valid, "R1", "out_valid after reset", int'(out_valid), 0);
        chk(!sym_err, "R1", "sym_err after reset", int'(sym_err), 0);
    endtask

    task automatic t_zero_rotation();
        run_symbol(7, 0, 0.0, 1, 1'b0, 0, "R6");
    endtask

    task automatic t_rotations();
        run_symbol(0, 1, 30.0, 2, 1'b0, 0, "R5");
        run_symbol(49, 3, -170.0, 3, 1'b0, 0, "R5");
    endtask

    task automatic t_code_map();
        run_symbol(20, 2, 0.0, 4, 1'b0, 0, "R11");
    endtask

    task automatic t_per_symbol();
        run_symbol(10, 0, 60.0, 5, 1'b0, 0, "R7");
        run_symbol(10, 0, -45.0, 6, 1'b0, 0, "R7");
    endtask

    task automatic t_partial();
        for (int j = 0; j < 20; j++) feed(j == 0, j, 9000, -9000);
        run_symbol(5, 1, 15.0, 7, 1'b0, 1, "R8");
    endtask

    task automatic t_stray();
        for (int j = 0; j < 5; j++) feed(1'b0, j, 12345, 2222);
        run_symbol(33, 0, -80.0, 8, 1'b0, 0, "R9");
    endtask

    task automatic t_backpressure();
        run_symbol(25, 3, 100.0, 9, 1'b1, 0, "R10");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_zero_rotation();
        t_rotations();
        t_code_map();
        t_per_symbol();
        t_partial();
        t_stray();
        t_backpressure();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule